// File: doc/BRIEF.md
# Clear-on-read interrupt status register

This block holds the interrupt flags of a stand-alone serial bus controller. It watches five event sources coming from the controller core: wake-up, receive data overrun, error or bus state change, transmit buffer released, and receive buffer holding a message. Each source has its own enable. When an enabled event fires, its flag is set and stays set. While any flag is set, the block pulls an open-drain interrupt request line low.

The host reads the register through a simple synchronous port. The read data always shows the current flags. A cycle in which the read strobe is high clears all five flags at the next clock edge. An event that arrives in that same cycle is kept, so it is not lost.

The receive flag does not simply follow the buffer level. It is set when a message first arrives. It is set again only when a release command leaves a further message pending. A read clears it even if more messages are waiting.

Top module: `irq_status_reg`

## Requirements
- R1: A synchronous active-high `rst` clears all five flags and drops `irq_oe`. The source history follows the inputs during reset, so input levels present when reset is released raise no flag.
- R2: `rd_data` shows the current flags on every cycle, with bit 4 wake-up, bit 3 overrun, bit 2 error, bit 1 transmit and bit 0 receive. Bits 7 to 5 always read as 1. `src_en` uses the same bit positions.
- R3: A cycle with `rd_stb` high clears every flag at the next clock edge. A flag whose event occurs in that same cycle is set after the edge.
- R4: A 0-to-1 transition of `ovr_sts` sets bit 3 one clock edge later when `src_en[3]` is 1.
- R5: Any change of `err_sts` or `bus_sts`, in either direction, sets bit 2 one edge later when `src_en[2]` is 1.
- R6: A 0-to-1 transition of `tx_sts` sets bit 1 one edge later when `src_en[1]` is 1.
- R7: A 0-to-1 transition of `rx_sts` sets bit 0 one edge later when `src_en[0]` is 1. After a read, a steadily high `rx_sts` does not set bit 0 again.
- R8: When `rel_rx_cmd` is sampled high, and `rx_sts` is still 1 at the following edge, bit 0 is set at that following edge (when `src_en[0]` is 1). If `rx_sts` is 0 by then, nothing is set.
- R9: A 1-to-0 transition of `sleep_mode` (sleep exited) sets bit 4 one edge later when `src_en[4]` is 1.
- R10: `sleep_req` sampled high sets bit 4 one edge later when `src_en[4]` is 1 and either `bus_active` is 1 or at least one flag is already set. Otherwise the request sets nothing.
- R11: An event whose enable bit is 0 when the event is sampled leaves its flag clear.
- R12: `irq_oe` is 1 exactly when at least one flag is set. `irq_o` is always 0.
- R13: Once set, a flag stays set on every following cycle until a read clears it, and new events add to the flags already set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| src_en | input | 5 | Per-source enables, same positions as the flags |
| ovr_sts | input | 1 | Receive data overrun status level |
| err_sts | input | 1 | Error status level |
| bus_sts | input | 1 | Bus status level |
| tx_sts | input | 1 | Transmit buffer released status level |
| rx_sts | input | 1 | Receive buffer holds at least one message |
| rel_rx_cmd | input | 1 | Release receive buffer command strobe |
| sleep_mode | input | 1 | Controller is in sleep mode |
| sleep_req | input | 1 | Host request to enter sleep, strobe |
| bus_active | input | 1 | Controller is taking part in bus traffic |
| rd_stb | input | 1 | Host read of the register, strobe |
| rd_data | output | 8 | Register contents: reserved ones and five flags |
| irq_oe | output | 1 | Drive enable of the open-drain interrupt line |
| irq_o | output | 1 | Data value of the interrupt line, constant 0 |

## Verification
Every edge, change and sleep-request event is sampled at one clock edge and appears in `rd_data` and `irq_oe` right after that edge. A read clears the flags at that same edge. The re-arm path after a release command takes one extra edge, because the command is registered first and `rx_sts` is tested at the following edge. The bench changes its inputs at the falling edge. At the rising edge, a behavioural model updates from the values the design sampled. The outputs are compared at the next falling edge, so each comparison lands after exactly the number of edges each result needs.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int NUM_SRC  = 5;

    localparam int IDX_RX   = 0;
    localparam int IDX_TX   = 1;
    localparam int IDX_ERR  = 2;
    localparam int IDX_OVR  = 3;
    localparam int IDX_WAKE = 4;

    typedef enum logic [1:0] {
        EDGE_RISE = 2'd0,
        EDGE_FALL = 2'd1,
        EDGE_ANY  = 2'd2
    } edge_kind_e;

    typedef logic [NUM_SRC-1:0] src_vec_t;

endpackage

// File: rtl/irq_edge_det.sv
// Registers the previous value of one or more level inputs and flags a
// transition of the selected kind on any of them.
module irq_edge_det
    import irq_pkg::*;
#(
    parameter int         W    = 1,
    parameter edge_kind_e KIND = EDGE_RISE
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] sig_i,
    output logic         evt_o
);

    typedef struct packed {
        logic [W-1:0] hist;
    } hist_st_t;

    hist_st_t     st_d, st_q;
    logic [W-1:0] edge_vec;

    generate
        if (KIND == EDGE_RISE) begin : g_rise
            assign edge_vec = sig_i & ~st_q.hist;
        end else if (KIND == EDGE_FALL) begin : g_fall
            assign edge_vec = ~sig_i & st_q.hist;
        end else begin : g_any
            assign edge_vec = sig_i ^ st_q.hist;
        end
    endgenerate

    // History follows the input during reset as well, so a level that is
    // already present when reset is released is not seen as an edge.
    always_comb begin
        st_d      = st_q;
        st_d.hist = sig_i;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign evt_o = !rst && (|edge_vec);

endmodule

// File: rtl/irq_rx_arm.sv
// Receive source: fires on the arrival of a message, and once more one
// clock after a release command if a further message is pending.
module irq_rx_arm
    import irq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic rx_sts_i,
    input  logic rel_cmd_i,
    output logic evt_o
);

    typedef struct packed {
        logic armed;
    } arm_st_t;

    arm_st_t st_d, st_q;
    logic    arrive_evt;

    irq_edge_det #(
        .W    (1),
        .KIND (EDGE_RISE)
    ) u_arrive (
        .clk   (clk),
        .rst   (rst),
        .sig_i (rx_sts_i),
        .evt_o (arrive_evt)
    );

    always_comb begin
        st_d       = st_q;
        st_d.armed = rel_cmd_i;
        if (rst) begin
            st_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign evt_o = !rst && (arrive_evt || (st_q.armed && rx_sts_i));

endmodule

// File: rtl/irq_wake_ctl.sv
// Wake-up source: sleep exit, or a sleep request that cannot be honoured
// because the bus is busy or an interrupt is already waiting.
module irq_wake_ctl
    import irq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sleep_mode_i,
    input  logic sleep_req_i,
    input  logic bus_active_i,
    input  logic pending_i,
    output logic evt_o
);

    logic exit_evt;
    logic refuse_evt;

    irq_edge_det #(
        .W    (1),
        .KIND (EDGE_FALL)
    ) u_exit (
        .clk   (clk),
        .rst   (rst),
        .sig_i (sleep_mode_i),
        .evt_o (exit_evt)
    );

    always_comb begin
        refuse_evt = sleep_req_i && (bus_active_i || pending_i);
        evt_o      = !rst && (exit_evt || refuse_evt);
    end

endmodule

// File: rtl/irq_status_reg.sv
// Top: gathers the five event sources, gates them with their enables,
// holds the flags until a host read and drives the open-drain request.
module irq_status_reg
    import irq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [4:0]         src_en,
    input  logic               ovr_sts,
    input  logic               err_sts,
    input  logic               bus_sts,
    input  logic               tx_sts,
    input  logic               rx_sts,
    input  logic               rel_rx_cmd,
    input  logic               sleep_mode,
    input  logic               sleep_req,
    input  logic               bus_active,
    input  logic               rd_stb,
    output logic [DATA_W-1:0]  rd_data,
    output logic               irq_oe,
    output logic               irq_o
);

    localparam int RSV_W = DATA_W - NUM_SRC;

    typedef struct packed {
        src_vec_t flags;
    } reg_st_t;

    reg_st_t  st_d, st_q;
    src_vec_t raw_vec;
    src_vec_t set_vec;
    logic     pending;

    assign pending = |st_q.flags;

    irq_edge_det #(
        .W    (1),
        .KIND (EDGE_RISE)
    ) u_ovr (
        .clk   (clk),
        .rst   (rst),
        .sig_i (ovr_sts),
        .evt_o (raw_vec[IDX_OVR])
    );

    irq_edge_det #(
        .W    (2),
        .KIND (EDGE_ANY)
    ) u_err (
        .clk   (clk),
        .rst   (rst),
        .sig_i ({bus_sts, err_sts}),
        .evt_o (raw_vec[IDX_ERR])
    );

    irq_edge_det #(
        .W    (1),
        .KIND (EDGE_RISE)
    ) u_tx (
        .clk   (clk),
        .rst   (rst),
        .sig_i (tx_sts),
        .evt_o (raw_vec[IDX_TX])
    );

    irq_rx_arm u_rx (
        .clk       (clk),
        .rst       (rst),
        .rx_sts_i  (rx_sts),
        .rel_cmd_i (rel_rx_cmd),
        .evt_o     (raw_vec[IDX_RX])
    );

    irq_wake_ctl u_wake (
        .clk          (clk),
        .rst          (rst),
        .sleep_mode_i (sleep_mode),
        .sleep_req_i  (sleep_req),
        .bus_active_i (bus_active),
        .pending_i    (pending),
        .evt_o        (raw_vec[IDX_WAKE])
    );

    assign set_vec = raw_vec & src_en;

    // The clear from a read is applied first and new events are ORed in
    // after it, so an event arriving in the read cycle survives.
    always_comb begin
        st_d = st_q;
        if (rd_stb) begin
            st_d.flags = '0;
        end
        st_d.flags = st_d.flags | set_vec;
        if (rst) begin
            st_d.flags = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    generate
        if (RSV_W > 0) begin : g_rsv
            assign rd_data = {{RSV_W{1'b1}}, st_q.flags};
        end else begin : g_norsv
            assign rd_data = st_q.flags[DATA_W-1:0];
        end
    endgenerate

    assign irq_oe = pending;
    assign irq_o  = 1'b0;

endmodule

// File: rtl/irq_status_reg_chk.sv
module irq_status_reg_chk
    import irq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [4:0]        src_en,
    input logic              ovr_sts,
    input logic              err_sts,
    input logic              bus_sts,
    input logic              tx_sts,
    input logic              rx_sts,
    input logic              rel_rx_cmd,
    input logic              sleep_mode,
    input logic              sleep_req,
    input logic              bus_active,
    input logic              rd_stb,
    input logic [DATA_W-1:0] rd_data,
    input logic              irq_oe,
    input logic              irq_o,
    input logic [4:0]        set_vec
);

    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (rd_data[NUM_SRC-1:0] == '0) && !irq_oe);

    a_r2_reserved_ones: assert property (@(posedge clk) disable iff (rst)
        &rd_data[DATA_W-1:NUM_SRC]);

    a_r3_read_keeps_new: assert property (@(posedge clk) disable iff (rst)
        rd_stb |=> rd_data[NUM_SRC-1:0] == $past(set_vec));

    a_r4_ovr_rise: assert property (@(posedge clk) disable iff (rst)
        ($rose(ovr_sts) && src_en[IDX_OVR]) |=> rd_data[IDX_OVR]);

    a_r5_err_change: assert property (@(posedge clk) disable iff (rst)
        ((!$stable(err_sts) || !$stable(bus_sts)) && src_en[IDX_ERR]) |=> rd_data[IDX_ERR]);

    a_r6_tx_rise: assert property (@(posedge clk) disable iff (rst)
        ($rose(tx_sts) && src_en[IDX_TX]) |=> rd_data[IDX_TX]);

    a_r7_rx_rise: assert property (@(posedge clk) disable iff (rst)
        ($rose(rx_sts) && src_en[IDX_RX]) |=> rd_data[IDX_RX]);

    a_r8_rx_rearm: assert property (@(posedge clk) disable iff (rst)
        ($past(rel_rx_cmd) && rx_sts && src_en[IDX_RX]) |=> rd_data[IDX_RX]);

    a_r9_sleep_exit: assert property (@(posedge clk) disable iff (rst)
        ($fell(sleep_mode) && src_en[IDX_WAKE]) |=> rd_data[IDX_WAKE]);

    a_r10_sleep_refused: assert property (@(posedge clk) disable iff (rst)
        (sleep_req && bus_active && src_en[IDX_WAKE]) |=> rd_data[IDX_WAKE]);

    a_r11_ovr_masked: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && !src_en[IDX_OVR]) |=> !rd_data[IDX_OVR]);

    a_r12_line: assert property (@(posedge clk) disable iff (rst)
        !irq_o && (irq_oe == (rd_data[NUM_SRC-1:0] != '0)));

    a_r13_sticky: assert property (@(posedge clk) disable iff (rst)
        !rd_stb |=> rd_data[NUM_SRC-1:0] == ($past(rd_data[NUM_SRC-1:0]) | $past(set_vec)));

endmodule

bind irq_status_reg irq_status_reg_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .src_en     (src_en),
    .ovr_sts    (ovr_sts),
    .err_sts    (err_sts),
    .bus_sts    (bus_sts),
    .tx_sts     (tx_sts),
    .rx_sts     (rx_sts),
    .rel_rx_cmd (rel_rx_cmd),
    .sleep_mode (sleep_mode),
    .sleep_req  (sleep_req),
    .bus_active (bus_active),
    .rd_stb     (rd_stb),
    .rd_data    (rd_data),
    .irq_oe     (irq_oe),
    .irq_o      (irq_o),
    .set_vec    (set_vec)
);

// File: tb/irq_status_reg_test.sv
`timescale 1ns/1ps
module irq_status_reg_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] src_en = 5'b11111;
    logic ovr_sts = 0, err_sts = 0, bus_sts = 0, tx_sts = 0, rx_sts = 0;
    logic rel_rx_cmd = 0, sleep_mode = 0, sleep_req = 0, bus_active = 0, rd_stb = 0;
    logic [7:0] rd_data;
    logic       irq_oe, irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    irq_status_reg uut (
        .clk(clk), .rst(rst), .src_en(src_en),
        .ovr_sts(ovr_sts), .err_sts(err_sts), .bus_sts(bus_sts),
        .tx_sts(tx_sts), .rx_sts(rx_sts), .rel_rx_cmd(rel_rx_cmd),
        .sleep_mode(sleep_mode), .sleep_req(sleep_req), .bus_active(bus_active),
        .rd_stb(rd_stb), .rd_data(rd_data), .irq_oe(irq_oe), .irq_o(irq_o)
    );

    // Behavioural reference: previous input levels and flag bits as plain bits.
    bit m_flag [5];
    bit p_ovr, p_err, p_bus, p_tx, p_rx, p_slp, m_arm;

    always @(posedge clk) begin
        bit ev [5];
        bit any;
        any = 0;
        for (int i = 0; i < 5; i++) any |= m_flag[i];
        if (rst) begin
            for (int i = 0; i < 5; i++) m_flag[i] = 0;
            m_arm = 0;
        end else begin
            ev[3] = ovr_sts && !p_ovr;
            ev[2] = (err_sts != p_err) || (bus_sts != p_bus);
            ev[1] = tx_sts && !p_tx;
            ev[0] = (rx_sts && !p_rx) || (m_arm && rx_sts);
            ev[4] = (!sleep_mode && p_slp) || (sleep_req && (bus_active || any));
            for (int i = 0; i < 5; i++) begin
                if (rd_stb) m_flag[i] = 0;
                if (ev[i] && src_en[i]) m_flag[i] = 1;
            end
            m_arm = rel_rx_cmd;
        end
        p_ovr = ovr_sts; p_err = err_sts; p_bus = bus_sts;
        p_tx = tx_sts; p_rx = rx_sts; p_slp = sleep_mode;
    end

    function automatic logic [7:0] model_word();
        logic [7:0] w;
        w = 8'hE0;
        for (int i = 0; i < 5; i++) w[i] = m_flag[i];
        return w;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%02h expected=%02h", req, what, act, exp);
        end
    endtask

    // One clock: rising edge updates design and model, compare at falling edge.
    task automatic tick();
        logic [7:0] exp;
        @(posedge clk);
        @(negedge clk);
        exp = model_word();
        check(rd_data === exp, cur_req, "rd_data", rd_data, exp);
        check(irq_oe === (exp[4:0] != 0), "R12", "irq_oe", {7'b0, irq_oe}, {7'b0, exp[4:0] != 0});
        check(irq_o === 1'b0, "R12", "irq_o", {7'b0, irq_o}, 8'h00);
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic host_read();
        rd_stb = 1; tick(); rd_stb = 0;
    endtask

    initial begin
        // R1: levels present through reset must not raise flags afterwards
        ovr_sts = 1; tx_sts = 1; rx_sts = 1; sleep_mode = 1; err_sts = 1;
        cyc(3);
        rst = 0;
        cyc(3);
        check(rd_data === 8'hE0, "R1", "after reset", rd_data, 8'hE0);
        check(irq_oe === 1'b0, "R2", "idle line", {7'b0, irq_oe}, 8'h00);

        // R9: sleep exit; falls of rise-only sources add nothing
        cur_req = "R9";
        ovr_sts = 0; tx_sts = 0; rx_sts = 0; sleep_mode = 0;
        tick();
        check(rd_data === 8'hF0, "R9", "wake on exit", rd_data, 8'hF0);
        cur_req = "R3"; host_read();
        check(rd_data === 8'hE0, "R3", "cleared", rd_data, 8'hE0);

        // R4
        cur_req = "R4"; ovr_sts = 1; tick();
        check(rd_data[3] === 1'b1, "R4", "overrun", rd_data, 8'hE8);
        cyc(2); ovr_sts = 0; cur_req = "R13"; cyc(2); host_read();

        // R5: both directions, both inputs
        cur_req = "R5"; bus_sts = 1; tick();
        check(rd_data === 8'hE4, "R5", "bus change", rd_data, 8'hE4);
        host_read(); err_sts = 0; tick();
        check(rd_data === 8'hE4, "R5", "error fall", rd_data, 8'hE4);
        host_read();

        // R6
        cur_req = "R6"; tx_sts = 1; tick();
        check(rd_data === 8'hE2, "R6", "tx released", rd_data, 8'hE2);
        host_read(); cyc(2); tx_sts = 0; tick();

        // R7: arrival, then read while messages remain
        cur_req = "R7"; rx_sts = 1; tick();
        check(rd_data === 8'hE1, "R7", "rx arrival", rd_data, 8'hE1);
        host_read(); cyc(3);
        check(rd_data === 8'hE0, "R7", "no reset while held", rd_data, 8'hE0);

        // R8: release leaving another message
        cur_req = "R8"; rel_rx_cmd = 1; tick(); rel_rx_cmd = 0;
        check(rd_data === 8'hE0, "R8", "not yet", rd_data, 8'hE0);
        tick();
        check(rd_data === 8'hE1, "R8", "re-armed", rd_data, 8'hE1);
        host_read();
        rel_rx_cmd = 1; tick(); rel_rx_cmd = 0; rx_sts = 0; tick();
        check(rd_data === 8'hE0, "R8", "last message released", rd_data, 8'hE0);

        // R10: refused sleep
        cur_req = "R10"; sleep_req = 1; tick(); sleep_req = 0;
        check(rd_data === 8'hE0, "R10", "idle sleep ok", rd_data, 8'hE0);
        bus_active = 1; sleep_req = 1; tick(); sleep_req = 0; bus_active = 0;
        check(rd_data === 8'hF0, "R10", "bus busy", rd_data, 8'hF0);
        host_read();
        tx_sts = 1; tick(); sleep_req = 1; tick(); sleep_req = 0;
        check(rd_data === 8'hF2, "R10", "pending flag", rd_data, 8'hF2);
        host_read(); tx_sts = 0; tick();

        // R3: event in the read cycle survives
        cur_req = "R3"; cyc(1); ovr_sts = 1; bus_sts = 0; rd_stb = 1; tick(); rd_stb = 0;
        check(rd_data === 8'hEC, "R3", "collision", rd_data, 8'hEC);
        host_read(); ovr_sts = 0; tick();

        // R11: every source masked
        cur_req = "R11"; src_en = 5'b00000;
        ovr_sts = 1; err_sts = 1; tx_sts = 1; rx_sts = 1; sleep_mode = 1; tick();
        sleep_mode = 0; bus_active = 1; sleep_req = 1; tick(); sleep_req = 0; bus_active = 0;
        rel_rx_cmd = 1; tick(); rel_rx_cmd = 0; tick();
        check(rd_data === 8'hE0, "R11", "masked", rd_data, 8'hE0);
        src_en = 5'b00010; tx_sts = 0; tick(); tx_sts = 1; tick();
        check(rd_data === 8'hE2, "R11", "single enable", rd_data, 8'hE2);

        // R13: accumulation
        cur_req = "R13"; src_en = 5'b11111; err_sts = 0; tick(); cyc(3);
        check(rd_data === 8'hE6, "R13", "accumulated", rd_data, 8'hE6);
        host_read(); cyc(2);

        // R1: reset with flags set
        cur_req = "R1"; bus_sts = 1; tick(); rst = 1; tick(); rst = 0; tick();
        check(rd_data === 8'hE0, "R1", "reset clears", rd_data, 8'hE0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule